// File: doc/BRIEF.md
# Two-Tap Pixel Output Formatter

This block sits between a two-tap line sensor and the parallel video outputs. It receives even and odd pixels in pairs, one pair per shift request it issues to the taps. It formats the pairs into a primary port, a secondary port, a line-valid flag and a strobe enable. Three output arrangements are available. The dual arrangement places the two taps side by side. The single arrangement interleaves both taps onto the primary port at twice the pair rate. The packed arrangement puts two 8-bit pixels into the primary port.

A synthetic stepped ramp can take the place of the sensor data so that the cabling and capture path can be checked. Samples can be cut down to 10 or 8 bits. The formatting setup is captured when a line begins, so a host may change the setup inputs at any time without disturbing a line in progress. The tap shift cadence is fixed at one pair every two clocks. The dual and packed strobes run at that pair rate, and the single strobe runs at every clock.

Top module: `tap_pixel_formatter`

## Requirements
- R1: After reset, line_valid, strobe-qualified data (pri_data, sec_data) and tap_shift are all low.
- R2: With mode code 0 (code 3 behaves the same), each strobe carries one pair: the even pixel on sec_data and the odd pixel on pri_data[11:0]. strobe_en is high on every second clock while the line is valid.
- R3: With mode code 1, pixels appear one per clock on pri_data[11:0], the even pixel of a pair before its odd pixel. strobe_en is high on every clock and sec_data stays zero.
- R4: Width code 0 outputs the full 12-bit sample. Code 1 outputs sample bits 11..2 and code 2 or 3 outputs bits 11..4, each right-aligned with zeros above.
- R5: With mode code 2, pri_data[7:0] carries even bits 11..4 and pri_data[15:8] carries odd bits 11..4. sec_data stays zero and the width code has no effect.
- R6: For each line, line_valid is high on exactly LINE_PIXELS pixel strobes (single) or LINE_PIXELS/2 pair strobes (dual, packed), forming one unbroken run.
- R7: A line start request that arrives while a line is running is ignored. Between two lines, at least one strobe has line_valid low.
- R8: With the test flag set, pixel p of the line (counting from 0 at the line start) takes the value (p mod 256) x 16 before width reduction, and the tap inputs are ignored.
- R9: Mode, width and test selections are sampled when a line starts. Changing them during the line has no effect until the next line.
- R10: Whenever line_valid is low, pri_data and sec_data are zero.
- R11: A line issues exactly LINE_PIXELS/2 tap_shift pulses, never on two consecutive clocks. The tap presents the pair on the clock after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 dual, 1 single, 2 packed, 3 dual |
| cfg_width | input | 2 | 0 12-bit, 1 10-bit, 2/3 8-bit |
| cfg_test | input | 1 | Replace tap data with the ramp |
| line_start | input | 1 | Request a line readout |
| tap_shift | output | 1 | Asks the taps for the next pair |
| tap_even | input | PIX_W | Even tap sample |
| tap_odd | input | PIX_W | Odd tap sample |
| pri_data | output | PRI_W | Primary (odd / multiplexed / packed) port |
| sec_data | output | PIX_W | Secondary (even) port |
| line_valid | output | 1 | High across the pixels of a line |
| strobe_en | output | 1 | Marks clocks whose data are to be strobed |

## Verification
The hardest case to reach is the boundary between two lines when the start request never drops. The last pair of one line and the first pair of the next then compete for the same strobe. The bench holds line_start high until the second line's first shift is seen. It then checks that two separate line_valid runs appear with a low strobe between them and that both carry correct data. A second hard case is a setup change while a line is in progress. The bench swaps every selection and sends a second start request partway through a line. It then confirms that the line finishes in its original format and that no extra line follows.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  typedef enum logic [1:0] {
    OM_DUAL   = 2'd0,
    OM_SINGLE = 2'd1,
    OM_PACKED = 2'd2,
    OM_DUAL_B = 2'd3
  } out_mode_e;

  typedef struct packed {
    out_mode_e  mode;
    logic [1:0] width;
    logic       test;
  } fmt_cfg_t;
endpackage

// File: rtl/pxf_line_seq.sv
module pxf_line_seq
  import pxf_pkg::*;
#(
  parameter int NPAIRS = 512,
  parameter int RAMP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  fmt_cfg_t            cfg_in,
  output logic                tick,
  output logic                tap_shift,
  output fmt_cfg_t            cfg_q,
  output logic                dv,
  output logic [RAMP_W-2:0]   ramp_pair
);
  localparam int CNT_W = (NPAIRS > 2) ? $clog2(NPAIRS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NPAIRS - 1);

  logic             run, armed;
  logic [CNT_W-1:0] cnt;
  logic [RAMP_W-2:0] rcnt;

  assign tap_shift = run & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick      <= 1'b0;
      run       <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      rcnt      <= '0;
      dv        <= 1'b0;
      ramp_pair <= '0;
      cfg_q     <= '{mode: OM_DUAL, width: 2'd0, test: 1'b0};
    end else begin
      tick      <= ~tick;
      dv        <= run & tick;
      ramp_pair <= rcnt;
      if (run) begin
        if (tick) begin
          rcnt <= rcnt + 1'b1;
          if (cnt == LAST) begin
            run <= 1'b0;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (armed) begin
        if (!tick) begin
          run   <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
          rcnt  <= '0;
          cfg_q <= cfg_in;
        end
      end else if (line_start) begin
        armed <= 1'b1;
      end
    end
  end

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_line_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |=> !run);
  p_shift_spacing_r11: assert property (@(posedge clk) disable iff (rst)
    tap_shift |=> !tap_shift);
endmodule

// File: rtl/pxf_src_sel.sv
module pxf_src_sel #(
  parameter int PIX_W  = 12,
  parameter int RAMP_W = 8
) (
  input  logic              test,
  input  logic [RAMP_W-2:0] ramp_pair,
  input  logic [PIX_W-1:0]  tap_even,
  input  logic [PIX_W-1:0]  tap_odd,
  output logic [PIX_W-1:0]  even_px,
  output logic [PIX_W-1:0]  odd_px
);
  localparam int PAD_W = PIX_W - RAMP_W;

  logic [PIX_W-1:0] ramp_e, ramp_o;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ramp_e = {ramp_pair, 1'b0, {PAD_W{1'b0}}};
      assign ramp_o = {ramp_pair, 1'b1, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign ramp_e = {ramp_pair, 1'b0};
      assign ramp_o = {ramp_pair, 1'b1};
    end
  endgenerate

  always_comb begin
    even_px = test ? ramp_e : tap_even;
    odd_px  = test ? ramp_o : tap_odd;
  end
endmodule

// File: rtl/pxf_out_fmt.sv
module pxf_out_fmt
  import pxf_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int MID_W    = 10,
  parameter int NARROW_W = 8,
  parameter int PACK_W   = 8,
  parameter int PRI_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dv,
  input  fmt_cfg_t         cfg,
  input  logic [PIX_W-1:0] even_px,
  input  logic [PIX_W-1:0] odd_px,
  output logic [PRI_W-1:0] pri_data,
  output logic [PIX_W-1:0] sec_data,
  output logic             line_valid,
  output logic             strobe_en
);
  logic [PIX_W-1:0] hold_o;
  logic             single;

  assign single = (cfg.mode == OM_SINGLE);

  function automatic logic [PIX_W-1:0] narrow(input logic [PIX_W-1:0] x,
                                              input logic [1:0] w);
    if (w == 2'd0)      return x;
    else if (w == 2'd1) return x >> (PIX_W - MID_W);
    else                return x >> (PIX_W - NARROW_W);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_data   <= '0;
      sec_data   <= '0;
      line_valid <= 1'b0;
      strobe_en  <= 1'b0;
      hold_o     <= '0;
    end else begin
      strobe_en <= single ? 1'b1 : ~tick;
      if (!tick) begin
        if (dv) begin
          line_valid <= 1'b1;
          case (cfg.mode)
            OM_SINGLE: begin
              pri_data <= PRI_W'(narrow(even_px, cfg.width));
              sec_data <= '0;
              hold_o   <= narrow(odd_px, cfg.width);
            end
            OM_PACKED: begin
              pri_data <= PRI_W'({odd_px[PIX_W-1 -: PACK_W], even_px[PIX_W-1 -: PACK_W]});
              sec_data <= '0;
            end
            default: begin
              pri_data <= PRI_W'(narrow(odd_px, cfg.width));
              sec_data <= narrow(even_px, cfg.width);
            end
          endcase
        end else begin
          line_valid <= 1'b0;
          pri_data   <= '0;
          sec_data   <= '0;
        end
      end else if (single && line_valid) begin
        pri_data <= PRI_W'(hold_o);
      end
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> (pri_data == '0 && sec_data == '0));
  p_single_sec_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (line_valid && single) |-> sec_data == '0);
  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (line_valid && cfg.width[1] && cfg.mode != OM_PACKED)
      |-> ((sec_data >> NARROW_W) == '0 && (pri_data >> NARROW_W) == '0));
endmodule

// File: rtl/tap_pixel_formatter.sv
module tap_pixel_formatter
  import pxf_pkg::*;
#(
  parameter int LINE_PIXELS = 1024,
  parameter int PIX_W       = 12,
  parameter int MID_W       = 10,
  parameter int NARROW_W    = 8,
  parameter int PACK_W      = 8,
  parameter int RAMP_W      = 8,
  parameter int PRI_W       = 2 * PACK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_test,
  input  logic             line_start,
  output logic             tap_shift,
  input  logic [PIX_W-1:0] tap_even,
  input  logic [PIX_W-1:0] tap_odd,
  output logic [PRI_W-1:0] pri_data,
  output logic [PIX_W-1:0] sec_data,
  output logic             line_valid,
  output logic             strobe_en
);
  localparam int NPAIRS = LINE_PIXELS / 2;

  fmt_cfg_t          cfg_in, cfg_q;
  logic              tick, dv;
  logic [RAMP_W-2:0] ramp_pair;
  logic [PIX_W-1:0]  even_px, odd_px;

  assign cfg_in = '{mode: out_mode_e'(cfg_mode), width: cfg_width, test: cfg_test};

  pxf_line_seq #(.NPAIRS(NPAIRS), .RAMP_W(RAMP_W)) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .cfg_in(cfg_in),
    .tick(tick), .tap_shift(tap_shift), .cfg_q(cfg_q), .dv(dv),
    .ramp_pair(ramp_pair)
  );

  pxf_src_sel #(.PIX_W(PIX_W), .RAMP_W(RAMP_W)) u_src (
    .test(cfg_q.test), .ramp_pair(ramp_pair), .tap_even(tap_even),
    .tap_odd(tap_odd), .even_px(even_px), .odd_px(odd_px)
  );

  pxf_out_fmt #(.PIX_W(PIX_W), .MID_W(MID_W), .NARROW_W(NARROW_W),
                .PACK_W(PACK_W), .PRI_W(PRI_W)) u_fmt (
    .clk(clk), .rst(rst), .tick(tick), .dv(dv), .cfg(cfg_q),
    .even_px(even_px), .odd_px(odd_px), .pri_data(pri_data),
    .sec_data(sec_data), .line_valid(line_valid), .strobe_en(strobe_en)
  );
endmodule

// File: tb/tap_pixel_formatter_bench.sv
module tap_pixel_formatter_bench;
  localparam int LP = 300;
  localparam int NP = LP / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0, cfg_width = 2'd0;
  logic        cfg_test = 1'b0, line_start = 1'b0;
  logic        tap_shift;
  logic [11:0] tap_even = '0, tap_odd = '0;
  logic [15:0] pri_data;
  logic [11:0] sec_data;
  logic        line_valid, strobe_en;

  int errors = 0, checks = 0;
  int nshift = 0, ncap = 0, rises = 0, nostb = 0, idle_bad = 0;
  int seed = 0, sbase = 0;
  logic prev_stb_lv = 1'b0;
  logic [15:0] cap_pri [0:4095];
  logic [11:0] cap_sec [0:4095];

  always #4 clk = ~clk;

  tap_pixel_formatter #(.LINE_PIXELS(LP)) u_tap_pixel_formatter (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_test(cfg_test), .line_start(line_start), .tap_shift(tap_shift),
    .tap_even(tap_even), .tap_odd(tap_odd), .pri_data(pri_data),
    .sec_data(sec_data), .line_valid(line_valid), .strobe_en(strobe_en)
  );

  function automatic logic [11:0] pv(input int p);
    return 12'((p * 53 + seed * 7 + 11) & 12'hFFF);
  endfunction

  function automatic logic [11:0] red(input logic [11:0] x, input int w);
    if (w == 0) return x;
    if (w == 1) return x >> 2;
    return x >> 4;
  endfunction

  function automatic logic [11:0] src(input int k, input int p, input bit t);
    if (t) return 12'((p % 256) * 16);
    return pv(k);
  endfunction

  // tap model: presents the requested pair on the clock after tap_shift
  always @(negedge clk) begin
    if (!rst && tap_shift) begin
      tap_even <= pv(2 * (nshift - sbase));
      tap_odd  <= pv(2 * (nshift - sbase) + 1);
      nshift   <= nshift + 1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (strobe_en) begin
        if (line_valid) begin
          cap_pri[ncap % 4096] = pri_data;
          cap_sec[ncap % 4096] = sec_data;
          ncap = ncap + 1;
          if (!prev_stb_lv) rises = rises + 1;
        end
        prev_stb_lv = line_valid;
      end else if (line_valid) begin
        nostb = nostb + 1;
      end
      if (!line_valid && (pri_data != 0 || sec_data != 0)) idle_bad = idle_bad + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_data(input int mode, input int w, input bit t,
                            input int cb, input int kbase, input string req);
    for (int j = 0; j < NP; j++) begin
      logic [11:0] e, o;
      e = src(2 * (kbase + j), 2 * j, t);
      o = src(2 * (kbase + j) + 1, 2 * j + 1, t);
      if (mode == 1) begin
        chk({req, " single even"}, int'(cap_pri[(cb + 2*j) % 4096]), int'(red(e, w)));
        chk({req, " single odd"},  int'(cap_pri[(cb + 2*j + 1) % 4096]), int'(red(o, w)));
        chk({req, " single sec"},  int'(cap_sec[(cb + 2*j) % 4096]), 0);
      end else if (mode == 2) begin
        chk({req, " packed pri"}, int'(cap_pri[(cb + j) % 4096]), int'({o[11:4], e[11:4]}));
        chk({req, " packed sec"}, int'(cap_sec[(cb + j) % 4096]), 0);
      end else begin
        chk({req, " dual odd"},  int'(cap_pri[(cb + j) % 4096]), int'(red(o, w)));
        chk({req, " dual even"}, int'(cap_sec[(cb + j) % 4096]), int'(red(e, w)));
      end
    end
  endtask

  task automatic wait_line_end(input int rb);
    for (int i = 0; i < 4 * LP + 40; i++) begin
      @(negedge clk);
      if (rises > rb && !line_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_line(input int mode, input int w, input bit t, input int sd,
                          input bit mid, input string req);
    int cb, rb, nb, n0;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_width = 2'(w); cfg_test = t;
    seed = sd; sbase = nshift;
    cb = ncap; rb = rises; nb = nostb; n0 = nshift;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    if (mid) begin
      repeat (40) @(negedge clk);
      cfg_mode = (mode == 1) ? 2'd0 : 2'd1; cfg_width = 2'd2; cfg_test = ~t;
      line_start = 1'b1;  // R7: ignored while running; R9: setup change ignored
      @(negedge clk);
      line_start = 1'b0;
    end
    wait_line_end(rb);
    chk({req, " R11 shifts"}, nshift - n0, NP);
    chk({req, " R6 pixel strobes"}, ncap - cb, (mode == 1) ? LP : NP);
    chk({req, " R6 single run"}, rises - rb, 1);
    chk({req, " R2/R3 strobe rate"}, nostb - nb, (mode == 1) ? 0 : NP);
    check_data(mode, w, t, cb, 0, req);
    if (mid) begin
      repeat (3 * LP) @(negedge clk);
      chk("R7 no extra line after ignored start", nshift - n0, NP);
    end
  endtask

  task automatic reset_test();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 line_valid", int'(line_valid), 0);
    chk("R1 pri_data", int'(pri_data), 0);
    chk("R1 sec_data", int'(sec_data), 0);
    chk("R1 tap_shift", int'(tap_shift), 0);
  endtask

  task automatic ramp_wrap_test();
    int cb;
    cb = ncap;
    run_line(0, 0, 1'b1, 9, 1'b0, "R8 ramp");
    // pixel 256 is the even pixel of pair 128: ramp restarts at 0
    chk("R8 ramp wraps at 256", int'(cap_sec[(cb + 128) % 4096]), 0);
    chk("R8 ramp pixel 257", int'(cap_pri[(cb + 128) % 4096]), 16);
  endtask

  task automatic back_to_back_test();
    int cb, rb, n0;
    @(negedge clk);
    cfg_mode = 2'd0; cfg_width = 2'd0; cfg_test = 1'b0; seed = 21;
    sbase = nshift; cb = ncap; rb = rises; n0 = nshift;
    line_start = 1'b1;
    for (int i = 0; i < 4 * LP; i++) begin
      @(negedge clk);
      if (nshift - n0 >= NP + 1) break;
    end
    line_start = 1'b0;
    wait_line_end(rb + 1);
    chk("R7 two separate runs", rises - rb, 2);
    chk("R7 pair strobes", ncap - cb, 2 * NP);
    check_data(0, 0, 1'b0, cb, 0, "R7 line one");
    check_data(0, 0, 1'b0, cb + NP, NP, "R7 line two");
  endtask

  task automatic summary();
    chk("R10 data zero while line_valid low", idle_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reset_test();
    run_line(0, 0, 1'b0, 1, 1'b0, "R2 dual 12b");
    run_line(1, 0, 1'b0, 2, 1'b0, "R3 single 12b");
    run_line(0, 1, 1'b0, 3, 1'b0, "R4 dual 10b");
    run_line(0, 2, 1'b0, 4, 1'b0, "R4 dual 8b");
    run_line(1, 3, 1'b0, 5, 1'b0, "R4 single code3");
    run_line(2, 1, 1'b0, 6, 1'b0, "R5 packed");
    ramp_wrap_test();
    run_line(1, 1, 1'b1, 7, 1'b0, "R8 ramp single");
    run_line(0, 0, 1'b0, 8, 1'b1, "R9 mid-line change");
    back_to_back_test();
    summary();
  end
endmodule